// File: doc/BRIEF.md
# Page Access Permission Checker with Fault Recording

This block sits behind a page-table walker. For every finished walk it receives the final entry's 3-bit access field and its modified bit, along with the kind of access: load, store or instruction fetch, in user or supervisor mode. It judges the access against a fixed permission map and returns one result per request. The result says whether translation proceeds, which read and write rights go with the mapping, and the raw check code. Requests enter and results leave on valid/ready streams. A request is taken only when the single result slot is empty or is being drained in the same cycle. While `resp_ready` is low, a waiting result holds all of its fields and `req_ready` stays low.

A fault updates a fault status register and a fault address register. When traps are enabled, a fault also produces a one-cycle trap request that marks it as an instruction or data fault. The no-fault mode input suppresses faults altogether. Disabling traps turns a fault into a full read/write mapping, but the fault is still recorded. Software reads both registers through a one-bit-select read port, and reading the status register clears it.

Top module: `access_guard`

## Requirements
- R1: The access index is {is_store (bit 2), is_fetch (bit 1), is_sup (bit 0)}. For an index and an access field, `resp_code` is 0 (allowed), 2 (protection error) or 3 (privilege error). Supervisor rights for fields 0 to 7 are: r, rw, rx, rwx, x, rw, rx, rwx. User rights for fields 0 to 5 are: r, rw, rx, rwx, x, r. A load needs r, a fetch needs x, a store needs w, and a store with the fetch bit needs w and x; a missing right gives 2.
- R2: Any user access (index bit 0 = 0) to field 6 or 7 gives code 3, whatever the access kind.
- R3: When translation proceeds, `resp_rd` is 1. When there is no recorded fault, `resp_wr` is 1 only if the modified bit is set and the field allows writing at that privilege: user fields 1 and 3, supervisor fields 1, 3, 5 and 7.
- R4: With `nofault_mode` high, a nonzero code does not fault. Translation proceeds with the R3 rights, no trap is raised and the fault registers are unchanged.
- R5: On a fault, the status register is first set to 1 if it was nonzero (overflow, bit 0), else to 0. It is then ORed with (index << 5) | code | 2, where bit 1 marks the fault address as valid.
- R6: On a fault, the request's virtual address is stored in the fault address register.
- R7: A fault with `traps_on` low is recorded as in R5 and R6. No trap is raised, and the result has `resp_ok`, `resp_rd` and `resp_wr` all set.
- R8: A fault with `traps_on` high gives `resp_ok`=0 and `resp_rd`=`resp_wr`=0. It pulses `trap_req` for one cycle together with the result, and `trap_fetch` equals the index fetch bit.
- R9: A `reg_rd` with `reg_sel`=0 returns the status register (zero-extended) on `reg_rdata` in the next cycle and clears it. With `reg_sel`=1 it returns the fault address and clears nothing.
- R10: The result appears one cycle after acceptance. While `resp_valid` is high and `resp_ready` is low, the result is held stable and `req_ready` is low.
- R11: After reset, no result is pending, `trap_req` is low, `req_ready` is high and both fault registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_field | input | 3 | Access field of the final page entry |
| req_modified | input | 1 | Modified bit of the final page entry |
| req_store | input | 1 | Access is a store |
| req_fetch | input | 1 | Access is an instruction fetch |
| req_sup | input | 1 | Access is in supervisor mode |
| req_va | input | VA_W | Virtual address of the access |
| nofault_mode | input | 1 | Suppress faults, let translation proceed |
| traps_on | input | 1 | Traps enabled |
| resp_valid | output | 1 | Result present |
| resp_ready | input | 1 | Result consumed this cycle when valid |
| resp_ok | output | 1 | Translation proceeds |
| resp_rd | output | 1 | Read right granted |
| resp_wr | output | 1 | Write right granted |
| resp_code | output | 2 | Check code: 0, 2 or 3 |
| trap_req | output | 1 | One-cycle trap request |
| trap_fetch | output | 1 | Trap is an instruction fault (1) or data fault (0) |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 1 | 0: fault status, 1: fault address |
| reg_rdata | output | VA_W | Read data, valid the cycle after the strobe |

## Verification
The bound checker checks the following on every cycle:
- a trap only comes with a held-back, nonzero result;
- a write right never comes without a read right, and a zero code always proceeds;
- a stalled result stays stable while the request side is blocked;
- no-fault mode never lets a trap out;
- a nonzero status always carries its address-valid bit;
- a status read with no accepted request leaves the register cleared.

Only the bench scenarios can show the following:
- the exact code for each of the 64 index/field pairs;
- the modified-bit rule for write rights;
- the overflow encoding after two faults without a read in between;
- the captured address values;
- the full read/write mapping when traps are disabled.

// File: rtl/access_guard_pkg.sv
`timescale 1ns/1ps
package access_guard_pkg;
  localparam int STAT_W  = 8;
  localparam int IDX_LSB = 5;
  localparam int FAV_BIT = 1;

  typedef enum logic [1:0] {
    CHK_OK   = 2'd0,
    CHK_PROT = 2'd2,
    CHK_PRIV = 2'd3
  } chk_code_e;

  typedef struct packed {
    logic is_store;
    logic is_fetch;
    logic is_sup;
  } acc_idx_t;
endpackage

// File: rtl/access_guard_perm.sv
`timescale 1ns/1ps
module access_guard_perm
  import access_guard_pkg::*;
(
  input  acc_idx_t   idx,
  input  logic [2:0] field,
  input  logic       modified,
  output chk_code_e  code,
  output logic       wr_grant
);
  localparam int NFIELD = 8;

  logic [NFIELD-1:0] u_r, u_w, u_x, s_r, s_w, s_x;

  for (genvar f = 0; f < NFIELD; f++) begin : g_field
    localparam logic [2:0] F = 3'(f);
    assign s_r[f] = (F != 3'd4);
    assign s_w[f] = F[0];
    assign s_x[f] = F[1] || (F == 3'd4);
    assign u_r[f] = (F <= 3'd3) || (F == 3'd5);
    assign u_w[f] = (F == 3'd1) || (F == 3'd3);
    assign u_x[f] = (F == 3'd2) || (F == 3'd3) || (F == 3'd4);
  end

  logic have_r, have_w, have_x, enough;

  always_comb begin
    have_r = idx.is_sup ? s_r[field] : u_r[field];
    have_w = idx.is_sup ? s_w[field] : u_w[field];
    have_x = idx.is_sup ? s_x[field] : u_x[field];
    unique case ({idx.is_store, idx.is_fetch})
      2'b00:   enough = have_r;
      2'b01:   enough = have_x;
      2'b10:   enough = have_w;
      default: enough = have_w && have_x;
    endcase
    if (!idx.is_sup && field[2] && field[1]) code = CHK_PRIV;
    else if (!enough)                        code = CHK_PROT;
    else                                     code = CHK_OK;
    wr_grant = modified && have_w;
  end
endmodule

// File: rtl/access_guard_fsr.sv
`timescale 1ns/1ps
module access_guard_fsr
  import access_guard_pkg::*;
#(
  parameter int VA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fault_we,
  input  acc_idx_t          fault_idx,
  input  chk_code_e         fault_code,
  input  logic [VA_W-1:0]   fault_va,
  input  logic              clr_stat,
  output logic [STAT_W-1:0] stat_q,
  output logic [VA_W-1:0]   far_q
);
  logic [STAT_W-1:0] base, merged;

  always_comb begin
    base   = clr_stat ? '0 : stat_q;
    merged = '0;
    merged[IDX_LSB +: 3] = fault_idx;
    merged[1:0] = {1'b1, |base} | 2'(fault_code);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      far_q  <= '0;
    end else if (fault_we) begin
      stat_q <= merged;
      far_q  <= fault_va;
    end else if (clr_stat) begin
      stat_q <= '0;
    end
  end
endmodule

// File: rtl/access_guard.sv
`timescale 1ns/1ps
module access_guard
  import access_guard_pkg::*;
#(
  parameter int VA_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [2:0]      req_field,
  input  logic            req_modified,
  input  logic            req_store,
  input  logic            req_fetch,
  input  logic            req_sup,
  input  logic [VA_W-1:0] req_va,
  input  logic            nofault_mode,
  input  logic            traps_on,
  output logic            resp_valid,
  input  logic            resp_ready,
  output logic            resp_ok,
  output logic            resp_rd,
  output logic            resp_wr,
  output logic [1:0]      resp_code,
  output logic            trap_req,
  output logic            trap_fetch,
  input  logic            reg_rd,
  input  logic            reg_sel,
  output logic [VA_W-1:0] reg_rdata
);
  acc_idx_t          idx;
  chk_code_e         code;
  logic              wr_grant;
  logic              accept, err, fault, trap_now, proceeds, wr_n;
  logic [STAT_W-1:0] stat_q;
  logic [VA_W-1:0]   far_q;

  assign idx = '{is_store: req_store, is_fetch: req_fetch, is_sup: req_sup};

  access_guard_perm u_perm (
    .idx      (idx),
    .field    (req_field),
    .modified (req_modified),
    .code     (code),
    .wr_grant (wr_grant)
  );

  assign req_ready = !resp_valid || resp_ready;
  assign accept    = req_valid && req_ready;
  assign err       = (code != CHK_OK);
  assign fault     = accept && err && !nofault_mode;
  assign trap_now  = fault && traps_on;
  assign proceeds  = !(err && !nofault_mode && traps_on);
  assign wr_n      = proceeds && ((err && !nofault_mode) || wr_grant);

  access_guard_fsr #(.VA_W(VA_W)) u_fsr (
    .clk        (clk),
    .rst_n      (rst_n),
    .fault_we   (fault),
    .fault_idx  (idx),
    .fault_code (code),
    .fault_va   (req_va),
    .clr_stat   (reg_rd && !reg_sel),
    .stat_q     (stat_q),
    .far_q      (far_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_ok    <= 1'b0;
      resp_rd    <= 1'b0;
      resp_wr    <= 1'b0;
      resp_code  <= 2'd0;
      trap_req   <= 1'b0;
      trap_fetch <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      if (accept) begin
        resp_valid <= 1'b1;
        resp_ok    <= proceeds;
        resp_rd    <= proceeds;
        resp_wr    <= wr_n;
        resp_code  <= code;
      end else if (resp_ready) begin
        resp_valid <= 1'b0;
      end
      trap_req   <= trap_now;
      trap_fetch <= trap_now && req_fetch;
      if (reg_rd) reg_rdata <= reg_sel ? far_q : VA_W'(stat_q);
    end
  end
endmodule

// File: rtl/access_guard_chk.sv
`timescale 1ns/1ps
module access_guard_chk
  import access_guard_pkg::*;
#(
  parameter int VA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              nofault_mode,
  input logic              resp_valid,
  input logic              resp_ready,
  input logic              resp_ok,
  input logic              resp_rd,
  input logic              resp_wr,
  input logic [1:0]        resp_code,
  input logic              trap_req,
  input logic              trap_fetch,
  input logic              reg_rd,
  input logic              reg_sel,
  input logic [STAT_W-1:0] stat_q
);
  p_trap_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> resp_valid && !resp_ok && resp_code != 2'd0);

  p_trap_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_req |-> !trap_fetch);

  p_wr_needs_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_wr |-> resp_rd);

  p_clean_ok_r1: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_code == 2'd0 |-> resp_ok && resp_rd);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid &&
      $stable({resp_ok, resp_rd, resp_wr, resp_code}));

  p_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |-> !req_ready);

  p_no_trap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && nofault_mode |=> !trap_req);

  p_fav_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q != '0 |-> stat_q[FAV_BIT]);

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && !reg_sel && !(req_valid && req_ready) |=> stat_q == '0);
endmodule

bind access_guard access_guard_chk #(.VA_W(VA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .nofault_mode (nofault_mode),
  .resp_valid   (resp_valid),
  .resp_ready   (resp_ready),
  .resp_ok      (resp_ok),
  .resp_rd      (resp_rd),
  .resp_wr      (resp_wr),
  .resp_code    (resp_code),
  .trap_req     (trap_req),
  .trap_fetch   (trap_fetch),
  .reg_rd       (reg_rd),
  .reg_sel      (reg_sel),
  .stat_q       (stat_q)
);

// File: tb/access_guard_tb.sv
`timescale 1ns/1ps
module access_guard_tb;
  localparam int VA_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_modified = 1'b0, req_store = 1'b0;
  logic req_fetch = 1'b0, req_sup = 1'b0;
  logic [2:0] req_field = 3'd0;
  logic [VA_W-1:0] req_va = '0;
  logic nofault_mode = 1'b0, traps_on = 1'b1, resp_ready = 1'b1;
  logic reg_rd = 1'b0, reg_sel = 1'b0;
  logic req_ready, resp_valid, resp_ok, resp_rd, resp_wr, trap_req, trap_fetch;
  logic [1:0] resp_code;
  logic [VA_W-1:0] reg_rdata;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [7:0] m_stat = 8'd0;
  logic [VA_W-1:0] m_far = '0;

  always #10 clk = ~clk;

  access_guard #(.VA_W(VA_W)) u_dut (.*);

  // Rows by index; field f code at bits [2f+1:2f].
  function automatic logic [1:0] exp_code(input logic [2:0] idx, input logic [2:0] f);
    logic [15:0] row;
    case (idx)
      3'd0: row = 16'hF200;
      3'd1: row = 16'h0200;
      3'd2: row = 16'hF80A;
      3'd3: row = 16'h080A;
      3'd4: row = 16'hFA22;
      3'd5: row = 16'h2222;
      3'd6: row = 16'hFA2A;
      default: row = 16'h2A2A;
    endcase
    return row[2*f +: 2];
  endfunction

  function automatic logic wperm(input logic sup, input logic [2:0] f);
    return sup ? f[0] : (f == 3'd1 || f == 3'd3);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [VA_W-1:0] act,
                       input logic [VA_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Sends one request with resp_ready high and checks its result and trap.
  task automatic do_req(input logic [2:0] f, input logic md, input logic st,
                        input logic fe, input logic su, input logic [VA_W-1:0] va,
                        input logic nf, input logic ton, input string tag);
    logic [2:0] idx;
    logic [1:0] c;
    logic flt, trp, ok;
    logic [7:0] exp_v, act_v;
    idx = {st, fe, su};
    c   = exp_code(idx, f);
    flt = (c != 2'd0) && !nf;
    trp = flt && ton;
    ok  = !trp;
    @(negedge clk);
    req_field = f; req_modified = md; req_store = st; req_fetch = fe;
    req_sup = su; req_va = va; nofault_mode = nf; traps_on = ton; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    exp_v = {1'b1, ok, ok, ok && (flt || (md && wperm(su, f))), c, trp, trp && fe};
    act_v = {resp_valid, resp_ok, resp_rd, resp_wr, resp_code, trap_req, trap_fetch};
    check(act_v == exp_v, tag, VA_W'(act_v), VA_W'(exp_v));
    if (flt) begin
      m_stat = ((m_stat != 8'd0) ? 8'd1 : 8'd0) | ({5'd0, idx} << 5) | {6'd0, c} | 8'd2;
      m_far  = va;
    end
  endtask

  task automatic rd_reg(input logic sel, input string tag);
    logic [VA_W-1:0] exp;
    exp = sel ? m_far : VA_W'(m_stat);
    @(negedge clk);
    reg_rd = 1'b1; reg_sel = sel;
    @(negedge clk);
    reg_rd = 1'b0;
    check(reg_rdata == exp, tag, reg_rdata, exp);
    if (!sel) m_stat = 8'd0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(!resp_valid && !trap_req && req_ready, "R11 idle outputs",
          VA_W'({resp_valid, trap_req, req_ready}), VA_W'(3'b001));
    rd_reg(1'b0, "R11 status zero");
    rd_reg(1'b1, "R11 address zero");

    // R2 user load field 6 -> privilege trap, data side
    do_req(3'd6, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1234_5000, 1'b0, 1'b1, "R2 R8 user load f6");
    @(negedge clk);
    check(!trap_req, "R8 trap one cycle", VA_W'(trap_req), 0);
    rd_reg(1'b1, "R6 fault address");
    rd_reg(1'b0, "R5 status after privilege fault");
    rd_reg(1'b0, "R9 status cleared by read");

    // R5 overflow: two faults without a read
    do_req(3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 32'hCAFE_0000, 1'b0, 1'b1, "R1 user store f0");
    do_req(3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0BAD_F000, 1'b0, 1'b1, "R8 user fetch f0 trap_fetch");
    rd_reg(1'b0, "R5 overflow status");
    rd_reg(1'b1, "R6 second fault address");

    // R3 write rights follow the modified bit
    do_req(3'd5, 1'b1, 1'b1, 1'b0, 1'b1, 32'h10, 1'b0, 1'b1, "R3 super store f5 modified");
    do_req(3'd5, 1'b0, 1'b1, 1'b0, 1'b1, 32'h20, 1'b0, 1'b1, "R3 super store f5 clean");
    do_req(3'd5, 1'b1, 1'b0, 1'b0, 1'b0, 32'h30, 1'b0, 1'b1, "R3 user load f5 no write");
    do_req(3'd3, 1'b1, 1'b1, 1'b0, 1'b0, 32'h40, 1'b0, 1'b1, "R3 user store f3");

    // R4 no-fault mode
    do_req(3'd7, 1'b1, 1'b0, 1'b0, 1'b0, 32'h50, 1'b1, 1'b1, "R4 nofault user f7");
    rd_reg(1'b0, "R4 status untouched");

    // R7 traps off
    do_req(3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h6000_0000, 1'b0, 1'b0, "R7 traps off mapped rw");
    rd_reg(1'b0, "R7 status recorded");
    rd_reg(1'b1, "R7 address recorded");

    // R10 back-pressure
    @(negedge clk);
    resp_ready = 1'b0;
    req_field = 3'd0; req_modified = 1'b0; req_store = 1'b0; req_fetch = 1'b0;
    req_sup = 1'b1; nofault_mode = 1'b0; traps_on = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    req_field = 3'd3; req_modified = 1'b1; req_fetch = 1'b1;
    check(resp_valid && !req_ready, "R10 stall blocks requests",
          VA_W'({resp_valid, req_ready}), VA_W'(2'b10));
    @(negedge clk);
    check({resp_valid, resp_ok, resp_rd, resp_wr, resp_code} == 6'b111000 && !req_ready,
          "R10 result held", VA_W'({resp_valid, resp_ok, resp_rd, resp_wr, resp_code}),
          VA_W'(6'b111000));
    resp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check({resp_valid, resp_ok, resp_rd, resp_wr, resp_code} == 6'b111100,
          "R10 second result after release",
          VA_W'({resp_valid, resp_ok, resp_rd, resp_wr, resp_code}), VA_W'(6'b111100));

    // Random mix: R1 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < 400; i++) begin
      do_req(3'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
             $urandom, ($urandom % 5) == 0, ($urandom % 4) != 0, "R1 R3 R7 R8 random");
      if (i % 7 == 6) rd_reg(1'($urandom), "R5 R6 R9 random read");
    end
    rd_reg(1'b0, "R5 final status");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule